// File: doc/BRIEF.md
# HDLC receive deframer with length register

The block takes a serial HDLC bit stream, one bit per cycle in which the bit qualifier is high. It finds opening and closing flags and seven-ones aborts, and it removes the zero inserted after every run of five ones. It packs the remaining bits into bytes, least significant bit first, and checks the CRC-16 frame check sequence (reflected polynomial 0x8408, initial value all ones, complemented FCS, good residue 0xF0B8). Payload bytes go into a receive FIFO, which the host drains one byte per read strobe. The two FCS bytes never reach the FIFO.

Every terminated frame leaves its committed bytes in the FIFO, whatever the outcome: good, bad FCS, aborted or invalid. At each termination the block latches three values: the number of bytes that frame stored, a 3-bit termination code and a 2-bit FIFO condition code. It also keeps a second copy of both codes that a host clear does not erase. The host compares the FIFO depth with the message length to find where the newest frame starts. This lets it queue lengths and codes and unload several short frames later.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: After reset the FIFO depth, message length, termination code, FIFO condition code, both kept codes and irq are all zero.
- R2: While rx_en is 0, incoming bits are ignored: nothing is written to the FIFO and no termination is reported. After rx_en returns to 1, the receiver waits for a flag before it accepts a frame.
- R3: A frame of at least 4 destuffed bytes that ends on a byte boundary and has a correct FCS reports termination code 010. Its payload bytes appear in the FIFO in arrival order without the FCS, and the message length equals the payload byte count.
- R4: A frame that is well formed but has a wrong FCS reports code 011 and leaves its payload bytes in the FIFO.
- R5: Seven consecutive ones inside a frame that has completed at least one byte report code 100. The rest of the frame is discarded. The two most recently completed bytes are not yet committed and are dropped, so the length equals the completed bytes minus two.
- R6: A frame with fewer than 4 destuffed bytes, or one that does not end on a byte boundary, reports code 101. The bytes it already committed stay in the FIFO.
- R7: fifo_depth counts the stored bytes. A read strobe on a non-empty FIFO removes the oldest byte and presents it on rd_data in the next cycle. A byte arriving while the FIFO is full is lost. The frame's FIFO condition code has bit 0 set if the FIFO became full during the frame and bit 1 set if a byte was lost.
- R8: irq rises after an end-of-message event, a FIFO-full event or an overflow event. It stays high until the host pulses stat_clr.
- R9: The message length, termination code and FIFO condition code hold until stat_clr (which zeroes them) or until the next termination overwrites them. last_term and last_fifo keep the most recent codes through stat_clr.
- R10: With several frames queued, fifo_depth minus msg_len gives the number of bytes that belong to earlier frames. Those bytes come out of the FIFO first.
- R11: A zero that follows five consecutive ones is removed, so payloads made of 0xFF and 0x7E bytes come through unchanged.
- R12: Back-to-back flags with no bits between them report no event and store nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable |
| rx_bit | input | 1 | Serial line bit |
| rx_bit_vld | input | 1 | rx_bit carries a new bit this cycle |
| rd_stb | input | 1 | Host read strobe for the FIFO data byte |
| stat_clr | input | 1 | Host clear of length, codes and pending interrupt |
| rd_data | output | 8 | Byte removed by the previous read strobe |
| fifo_depth | output | AW+1 | Number of bytes stored in the FIFO |
| msg_len | output | LEN_W | Bytes stored by the last terminated frame |
| term_stat | output | 3 | Termination code: 000 none, 010 good, 011 bad FCS, 100 abort, 101 invalid |
| fifo_stat | output | 2 | FIFO condition during the last frame: bit 0 full, bit 1 overflow |
| last_term | output | 3 | Kept copy of the last termination code |
| last_fifo | output | 2 | Kept copy of the last FIFO condition code |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that FIFO_DEPTH is a power of two and that rx_bit carries meaning only in cycles where rx_bit_vld is high. They also assume that stat_clr never falls in the same cycle as a frame termination, because the termination would then win and the clear would be lost. The stimulus respects these limits: frames are separated by idle cycles, clears come only after the pipeline has settled, and reads are issued only while bytes remain. Stuffing is applied correctly everywhere except the deliberate abort runs and the misaligned tail.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  typedef enum logic [2:0] {
    TERM_NONE    = 3'b000,
    TERM_GOOD    = 3'b010,
    TERM_BADFCS  = 3'b011,
    TERM_ABORT   = 3'b100,
    TERM_INVALID = 3'b101
  } term_e;

  localparam logic [15:0] FCS_POLY_REFL   = 16'h8408;
  localparam logic [15:0] FCS_INIT        = 16'hFFFF;
  localparam logic [15:0] FCS_GOOD_RESID  = 16'hF0B8;
  localparam int          MIN_FRAME_BYTES = 4;

  // One byte through the reflected CRC-16, least significant bit first.
  function automatic logic [15:0] fcs_byte(input logic [15:0] crc_in, input logic [7:0] d);
    logic [15:0] c;
    c = crc_in;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ d[i]) c = (c >> 1) ^ FCS_POLY_REFL;
      else             c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/hdlc_unstuff.sv
module hdlc_unstuff (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic bit_i,
  input  logic vld_i,
  output logic dbit_o,
  output logic dvld_o,
  output logic flag_o,
  output logic abort_o
);
  logic [2:0] ones;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      ones    <= 3'd0;
      dbit_o  <= 1'b0;
      dvld_o  <= 1'b0;
      flag_o  <= 1'b0;
      abort_o <= 1'b0;
    end else begin
      dvld_o  <= 1'b0;
      flag_o  <= 1'b0;
      abort_o <= 1'b0;
      if (vld_i) begin
        if (bit_i) begin
          if (ones == 3'd6) begin
            abort_o <= 1'b1;
            ones    <= 3'd7;
          end else if (ones != 3'd7) begin
            ones   <= ones + 3'd1;
            dbit_o <= 1'b1;
            dvld_o <= 1'b1;
          end
        end else begin
          ones <= 3'd0;
          if (ones == 3'd6) begin
            flag_o <= 1'b1;
          end else if (ones < 3'd5) begin
            dbit_o <= 1'b0;
            dvld_o <= 1'b1;
          end
        end
      end
    end
  end

  // R11: the zero after five ones never becomes a data bit
  a_r11_stuffed_zero_dropped: assert property (@(posedge clk) disable iff (rst)
    (en && vld_i && !bit_i && ones == 3'd5) |=> !dvld_o);

  // R12: a flag and an abort are never reported together
  a_r12_flag_abort_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(flag_o && abort_o));

endmodule

// File: rtl/hdlc_frame_asm.sv
module hdlc_frame_asm
  import hdlc_rx_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       dbit_i,
  input  logic       dvld_i,
  input  logic       flag_i,
  input  logic       abort_i,
  output logic       wr_o,
  output logic [7:0] wr_data_o,
  output logic       term_o,
  output term_e      term_code_o
);
  logic             in_frame;
  logic [7:0]       shreg;
  logic [2:0]       bitcnt;
  logic [CNT_W-1:0] nbytes;
  logic [15:0]      crc;
  logic [7:0]       hold0, hold1;
  logic [1:0]       held_n;
  logic [7:0]       new_byte;

  assign new_byte = {dbit_i, shreg[7:1]};

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      in_frame    <= 1'b0;
      shreg       <= 8'd0;
      bitcnt      <= 3'd0;
      nbytes      <= '0;
      crc         <= FCS_INIT;
      hold0       <= 8'd0;
      hold1       <= 8'd0;
      held_n      <= 2'd0;
      wr_o        <= 1'b0;
      wr_data_o   <= 8'd0;
      term_o      <= 1'b0;
      term_code_o <= TERM_NONE;
    end else begin
      wr_o   <= 1'b0;
      term_o <= 1'b0;
      if (flag_i) begin
        if (in_frame && (nbytes != '0 || bitcnt != 3'd7)) begin
          term_o <= 1'b1;
          if (bitcnt != 3'd7 || nbytes < CNT_W'(MIN_FRAME_BYTES))
            term_code_o <= TERM_INVALID;
          else if (crc == FCS_GOOD_RESID)
            term_code_o <= TERM_GOOD;
          else
            term_code_o <= TERM_BADFCS;
        end
        in_frame <= 1'b1;
        bitcnt   <= 3'd0;
        nbytes   <= '0;
        crc      <= FCS_INIT;
        held_n   <= 2'd0;
      end else if (abort_i) begin
        if (in_frame && nbytes != '0) begin
          term_o      <= 1'b1;
          term_code_o <= TERM_ABORT;
        end
        in_frame <= 1'b0;
        bitcnt   <= 3'd0;
        nbytes   <= '0;
        crc      <= FCS_INIT;
        held_n   <= 2'd0;
      end else if (dvld_i && in_frame) begin
        shreg  <= new_byte;
        bitcnt <= bitcnt + 3'd1;
        if (bitcnt == 3'd7) begin
          crc <= fcs_byte(crc, new_byte);
          if (nbytes != '1) nbytes <= nbytes + CNT_W'(1);
          if (held_n == 2'd2) begin
            wr_o      <= 1'b1;
            wr_data_o <= hold1;
          end else begin
            held_n <= held_n + 2'd1;
          end
          hold1 <= hold0;
          hold0 <= new_byte;
        end
      end
    end
  end

  // R5: an abort never commits a byte
  a_r5_abort_no_write: assert property (@(posedge clk) disable iff (rst)
    abort_i |=> !wr_o);

  // R6: reported codes are always from the defined set
  a_r6_code_legal: assert property (@(posedge clk) disable iff (rst)
    term_o |-> term_code_o inside {TERM_GOOD, TERM_BADFCS, TERM_ABORT, TERM_INVALID});

endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  output logic [DW-1:0] rdata_o,
  output logic [AW:0]   count_o,
  output logic          acc_o,
  output logic          full_evt_o,
  output logic          ovf_evt_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          full, empty, wr_ok, rd_ok;

  assign full       = (count_o == (AW+1)'(DEPTH));
  assign empty      = (count_o == '0);
  assign wr_ok      = wr_i && !full;
  assign rd_ok      = rd_i && !empty;
  assign acc_o      = wr_ok;
  assign ovf_evt_o  = wr_i && full;
  assign full_evt_o = wr_ok && !rd_ok && (count_o == (AW+1)'(DEPTH - 1));

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr    <= '0;
      rptr    <= '0;
      count_o <= '0;
      rdata_o <= '0;
    end else begin
      if (wr_ok) wptr <= wptr + AW'(1);
      if (rd_ok) begin
        rptr    <= rptr + AW'(1);
        rdata_o <= mem[rptr];
      end
      if (wr_ok && !rd_ok)      count_o <= count_o + (AW+1)'(1);
      else if (rd_ok && !wr_ok) count_o <= count_o - (AW+1)'(1);
    end
  end

  a_r7_depth_bound: assert property (@(posedge clk) disable iff (rst)
    count_o <= (AW+1)'(DEPTH));

  a_r7_full_drops_write: assert property (@(posedge clk) disable iff (rst)
    (wr_i && full && !rd_i) |=> count_o == $past(count_o));

  a_r7_read_removes_one: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !empty && !wr_i) |=> count_o == $past(count_o) - (AW+1)'(1));

endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int LEN_W      = 8,
  localparam int AW        = $clog2(FIFO_DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_en,
  input  logic             rx_bit,
  input  logic             rx_bit_vld,
  input  logic             rd_stb,
  input  logic             stat_clr,
  output logic [7:0]       rd_data,
  output logic [AW:0]      fifo_depth,
  output logic [LEN_W-1:0] msg_len,
  output logic [2:0]       term_stat,
  output logic [1:0]       fifo_stat,
  output logic [2:0]       last_term,
  output logic [1:0]       last_fifo,
  output logic             irq
);
  logic       dbit, dvld, flag, abrt;
  logic       fifo_wr, fifo_acc, full_evt, ovf_evt, term_v;
  logic [7:0] fifo_wdata;
  term_e      term_code;

  logic [LEN_W-1:0] len_cnt;
  logic [1:0]       frm_fs;
  logic [1:0]       evt_pend;

  hdlc_unstuff u_unstuff (
    .clk(clk), .rst(rst), .en(rx_en), .bit_i(rx_bit), .vld_i(rx_bit_vld),
    .dbit_o(dbit), .dvld_o(dvld), .flag_o(flag), .abort_o(abrt)
  );

  hdlc_frame_asm #(.CNT_W(LEN_W)) u_asm (
    .clk(clk), .rst(rst), .en(rx_en), .dbit_i(dbit), .dvld_i(dvld),
    .flag_i(flag), .abort_i(abrt), .wr_o(fifo_wr), .wr_data_o(fifo_wdata),
    .term_o(term_v), .term_code_o(term_code)
  );

  hdlc_rx_fifo #(.DW(8), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr_i(fifo_wr), .wdata_i(fifo_wdata), .rd_i(rd_stb),
    .rdata_o(rd_data), .count_o(fifo_depth), .acc_o(fifo_acc),
    .full_evt_o(full_evt), .ovf_evt_o(ovf_evt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      len_cnt   <= '0;
      frm_fs    <= 2'b00;
      evt_pend  <= 2'b00;
      msg_len   <= '0;
      term_stat <= 3'b000;
      fifo_stat <= 2'b00;
      last_term <= 3'b000;
      last_fifo <= 2'b00;
      irq       <= 1'b0;
    end else begin
      if (!rx_en) begin
        len_cnt <= '0;
        frm_fs  <= 2'b00;
      end else begin
        if (fifo_acc && len_cnt != '1) len_cnt <= len_cnt + LEN_W'(1);
        frm_fs <= frm_fs | {ovf_evt, full_evt};
      end
      evt_pend <= evt_pend | {ovf_evt, full_evt};
      if (stat_clr) begin
        msg_len   <= '0;
        term_stat <= 3'b000;
        fifo_stat <= 2'b00;
        evt_pend  <= 2'b00;
      end
      if (term_v) begin
        msg_len   <= len_cnt;
        term_stat <= term_code;
        fifo_stat <= frm_fs;
        last_term <= term_code;
        last_fifo <= frm_fs;
        len_cnt   <= '0;
        frm_fs    <= 2'b00;
      end
      irq <= (term_stat != 3'b000) || (evt_pend != 2'b00);
    end
  end

  // R9: length register changes only on a termination or a host clear
  a_r9_len_hold: assert property (@(posedge clk) disable iff (rst)
    (!term_v && !stat_clr) |=> $stable(msg_len));

  // R2: nothing reaches the FIFO while the receiver is disabled
  a_r2_disabled_no_store: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> !fifo_wr);

  // R8: an overflow event is followed by a raised interrupt two cycles on
  a_r8_irq_on_overflow: assert property (@(posedge clk) disable iff (rst)
    (ovf_evt && !stat_clr) ##1 !stat_clr |=> irq);

endmodule

// File: tb/hdlc_rx_deframer_tb_top.sv
module hdlc_rx_deframer_tb_top;
  localparam int DEPTH = 16;
  localparam int LW    = 8;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst, rx_en, rx_bit, rx_bit_vld, rd_stb, stat_clr;
  logic [7:0]    rd_data;
  logic [AW:0]   fifo_depth;
  logic [LW-1:0] msg_len;
  logic [2:0]    term_stat, last_term;
  logic [1:0]    fifo_stat, last_fifo;
  logic          irq;

  hdlc_rx_deframer #(.FIFO_DEPTH(DEPTH), .LEN_W(LW)) dut_i (
    .clk(clk), .rst(rst), .rx_en(rx_en), .rx_bit(rx_bit), .rx_bit_vld(rx_bit_vld),
    .rd_stb(rd_stb), .stat_clr(stat_clr), .rd_data(rd_data), .fifo_depth(fifo_depth),
    .msg_len(msg_len), .term_stat(term_stat), .fifo_stat(fifo_stat),
    .last_term(last_term), .last_fifo(last_fifo), .irq(irq)
  );

  int n_chk = 0;
  int n_bad = 0;
  int ones_tx = 0;

  // kind: 0 good FCS, 1 corrupted FCS, 2 abort after payload, 3 three extra bits before the flag
  typedef struct packed {
    logic [7:0] npay;
    logic [1:0] kind;
    logic [7:0] seed;
    logic [2:0] term;
    logic [1:0] fst;
    logic [7:0] len;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'd4,  2'd0, 8'h11, 3'b010, 2'b00, 8'd4},   // R3 good frame
    '{8'd6,  2'd0, 8'hFF, 3'b010, 2'b00, 8'd6},   // R11 flag-like payload bytes
    '{8'd5,  2'd1, 8'h22, 3'b011, 2'b00, 8'd5},   // R4 bad FCS
    '{8'd9,  2'd2, 8'h33, 3'b100, 2'b00, 8'd7},   // R5 abort, two held bytes dropped
    '{8'd1,  2'd0, 8'h44, 3'b101, 2'b00, 8'd1},   // R6 three bytes is too short
    '{8'd5,  2'd3, 8'h55, 3'b101, 2'b00, 8'd6},   // R6 not byte aligned
    '{8'd16, 2'd0, 8'h66, 3'b010, 2'b01, 8'd16},  // R7 frame fills the FIFO exactly
    '{8'd2,  2'd0, 8'h77, 3'b010, 2'b00, 8'd2}    // R3 shortest valid frame
  };

  function automatic logic [7:0] pay(input logic [7:0] seed, input int i);
    return i[0] ? seed : (seed ^ 8'h81);
  endfunction

  function automatic string req_of(input logic [2:0] t);
    case (t)
      3'b010:  return "R3";
      3'b011:  return "R4";
      3'b100:  return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_bit_vld = 1'b0;
    end
  endtask

  task automatic send_raw(input logic b);
    @(negedge clk);
    rx_bit     = b;
    rx_bit_vld = 1'b1;
  endtask

  task automatic send_flag();
    send_raw(1'b0);
    for (int i = 0; i < 6; i++) send_raw(1'b1);
    send_raw(1'b0);
    ones_tx = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      send_raw(b[i]);
      if (b[i]) begin
        ones_tx++;
        if (ones_tx == 5) begin
          send_raw(1'b0);
          ones_tx = 0;
        end
      end else begin
        ones_tx = 0;
      end
    end
  endtask

  task automatic send_frame(input int n, input int kind, input logic [7:0] seed);
    logic [15:0] crc;
    logic [15:0] fcs;
    logic        fb;
    crc = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < 8; k++) begin
        fb  = crc[0] ^ pay(seed, i)[k];
        crc = {1'b0, crc[15:1]};
        if (fb) crc = crc ^ 16'h8408;
      end
    end
    fcs = ~crc;
    if (kind == 1) fcs = fcs ^ 16'h0100;
    send_flag();
    for (int i = 0; i < n; i++) send_byte(pay(seed, i));
    if (kind == 2) begin
      for (int i = 0; i < 8; i++) send_raw(1'b1);
      ones_tx = 0;
    end else begin
      send_byte(fcs[7:0]);
      send_byte(fcs[15:8]);
      if (kind == 3) begin
        for (int i = 0; i < 3; i++) send_raw(1'b0);
      end
      send_flag();
    end
    idle(10);
  endtask

  task automatic rd_byte(output logic [7:0] b);
    @(negedge clk);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    b = rd_data;
  endtask

  task automatic host_clear();
    @(negedge clk);
    stat_clr = 1'b1;
    @(negedge clk);
    stat_clr = 1'b0;
    idle(3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] b;
    int         nrd;
    rst = 1'b1; rx_en = 1'b0; rx_bit = 1'b0; rx_bit_vld = 1'b0; rd_stb = 1'b0; stat_clr = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle(2);
    // R1 reset state
    check("R1", "depth", int'(fifo_depth), 0);
    check("R1", "length", int'(msg_len), 0);
    check("R1", "term", int'(term_stat), 0);
    check("R1", "fifo code", int'(fifo_stat), 0);
    check("R1", "kept term", int'(last_term), 0);
    check("R1", "irq", int'(irq), 0);
    rx_en = 1'b1;
    idle(2);

    for (int v = 0; v < 8; v++) begin
      send_frame(int'(VECS[v].npay), int'(VECS[v].kind), VECS[v].seed);
      check(req_of(VECS[v].term), "term code", int'(term_stat), int'(VECS[v].term));
      check(req_of(VECS[v].term), "length", int'(msg_len), int'(VECS[v].len));
      check("R7", "fifo code", int'(fifo_stat), int'(VECS[v].fst));
      check("R8", "irq after end of message", int'(irq), 1);
      check("R7", "depth before drain", int'(fifo_depth), int'(VECS[v].len));
      nrd = int'(VECS[v].len);
      for (int i = 0; i < nrd; i++) begin
        rd_byte(b);
        if (i < int'(VECS[v].npay)) check("R7", "fifo byte", int'(b), int'(pay(VECS[v].seed, i)));
      end
      idle(1);
      check("R7", "depth after drain", int'(fifo_depth), 0);
      host_clear();
    end

    // R10: a short good frame followed by an aborted one, both queued
    send_frame(3, 0, 8'h10);
    check("R10", "first length", int'(msg_len), 3);
    send_frame(9, 2, 8'h20);
    check("R10", "depth", int'(fifo_depth), 10);
    check("R10", "length", int'(msg_len), 7);
    check("R10", "kept term", int'(last_term), 3'b100);
    check("R10", "older bytes", int'(fifo_depth) - int'(msg_len), 3);
    for (int i = 0; i < 3; i++) begin
      rd_byte(b);
      check("R10", "older frame byte", int'(b), int'(pay(8'h10, i)));
    end
    for (int i = 0; i < 7; i++) begin
      rd_byte(b);
      check("R10", "aborted frame byte", int'(b), int'(pay(8'h20, i)));
    end

    // R9: clear zeroes live registers, kept codes survive
    idle(4);
    check("R9", "length held", int'(msg_len), 7);
    host_clear();
    check("R9", "length cleared", int'(msg_len), 0);
    check("R9", "term cleared", int'(term_stat), 0);
    check("R9", "kept term survives", int'(last_term), 3'b100);
    check("R8", "irq cleared", int'(irq), 0);

    // R2: disabled receiver ignores a complete good frame
    rx_en = 1'b0;
    send_frame(4, 0, 8'h5A);
    check("R2", "depth while disabled", int'(fifo_depth), 0);
    check("R2", "term while disabled", int'(term_stat), 0);
    check("R2", "irq while disabled", int'(irq), 0);
    rx_en = 1'b1;
    idle(2);

    // R12: back-to-back flags
    send_flag(); send_flag(); send_flag();
    idle(10);
    check("R12", "term after idle flags", int'(term_stat), 0);
    check("R12", "depth after idle flags", int'(fifo_depth), 0);
    check("R12", "irq after idle flags", int'(irq), 0);

    // R7/R8: overflow of the FIFO by a 20-byte payload
    send_frame(20, 0, 8'hC3);
    check("R7", "depth at overflow", int'(fifo_depth), DEPTH);
    check("R7", "length at overflow", int'(msg_len), DEPTH);
    check("R7", "fifo code full and overflow", int'(fifo_stat), 3);
    check("R3", "term with overflow", int'(term_stat), 3'b010);
    check("R8", "irq at overflow", int'(irq), 1);
    for (int i = 0; i < DEPTH; i++) begin
      rd_byte(b);
      check("R7", "kept byte", int'(b), int'(pay(8'hC3, i)));
    end
    idle(1);
    check("R7", "depth drained", int'(fifo_depth), 0);
    host_clear();
    check("R8", "irq after final clear", int'(irq), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule